// File: doc/BRIEF.md
# Masked Configuration Register File

This block keeps the configuration space of one bus function as a byte-addressed store. A second store of equal size holds one write-mask byte per location. A requester reads or writes 1, 2 or 4 bytes at any byte offset. On every normal write, each stored byte keeps the bits whose mask is clear and takes the new data only where the mask is set. Because of this rule, identity fields stay fixed and base-address sizing probes read back the right value, with no separate sizing mode.

A byte-wide load port sets values and mask bytes directly, with no masking. Setup logic uses it to place identity fields and write masks before normal traffic starts. Data travels little-endian: the byte at the access offset sits in bits 7:0. The address space covers `2**ADDR_W` bytes (4096 by default). Only the lowest `MEM_BYTES` of them have storage behind them.

Top module: `cfg_regfile`

## Requirements
- R1: After reset every value byte and every mask byte is zero, `rsp_valid` is low, and a read of offset 0 returns 0.
- R2: A read request (`req_valid` high, `req_write` low) raises `rsp_valid` for exactly one cycle, one cycle later. `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. The byte at the offset is in bits 7:0 and the following bytes are in the next lanes upward. Lanes beyond the access size read 0.
- R3: A normal write changes each addressed byte to (old AND NOT mask) OR (new AND mask), using that byte's own mask.
- R4: A read whose last byte would lie past the end of the space returns 0xFF in every lane of the access, including the lanes that are in range.
- R5: A write whose last byte would lie past the end of the space changes no byte, including the bytes that are in range.
- R6: The load port writes a value byte (`init_sel` = 0) or a mask byte (`init_sel` = 1) at `init_offset` with no masking. Mask bytes change only through this port.
- R7: With the command mask loaded as 0x07 at offset 0x04 and 0x05 at offset 0x05, writing 0xFFFF to offset 0x04 reads back 0x0507. The writable bits are I/O, memory, bus master (bits 2:0), error reporting (bit 8) and interrupt-line disable (bit 10).
- R8: Bytes whose mask is zero, such as the identity fields at 0x00–0x03 and 0x08–0x0B, keep their loaded value under any normal write.
- R9: An access that is not aligned but stays inside the space returns the stored bytes, not all-ones.
- R10: When the load port and a normal write hit the same byte in the same cycle, the load port's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_offset | input | ADDR_W | Byte offset of the first byte |
| req_wdata | input | 32 | Write data, little-endian lanes |
| init_valid | input | 1 | Load port strobe |
| init_sel | input | 1 | 0 = value byte, 1 = mask byte |
| init_offset | input | ADDR_W | Byte offset for the load |
| init_data | input | 8 | Byte to load |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, little-endian lanes |

## Verification
The hardest case to reach is an access that straddles the end of the space, where some bytes are in range and hold known non-zero data. At the default 4 KiB size those edge bytes have no storage, so the effect could not be observed. The bench therefore sizes the space to equal the store, fills the last four bytes through a fully open mask, and then issues 2- and 4-byte accesses that overhang the edge. The data left behind shows that both the straddling read and the straddling write were refused. The bench also drives a load and a normal write to one byte in the same cycle, which normal setup never does.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
   localparam int LANES = 4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WALT = 2'd3
   } acc_size_e;

   function automatic logic [2:0] acc_bytes(acc_size_e s);
      case (s)
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/cfgrf_lane_decode.sv
module cfgrf_lane_decode
   import cfgrf_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0]               offset,
   input  acc_size_e                       size,
   output logic [LANES-1:0][ADDR_W:0]      lane_addr,
   output logic [LANES-1:0]                lane_act,
   output logic                            oob
);
   localparam int LANE_AW     = ADDR_W + 1;
   localparam int SPACE_BYTES = 1 << ADDR_W;

   logic [2:0]         nb;
   logic [LANE_AW-1:0] end_ext;

   always_comb begin
      nb      = acc_bytes(size);
      end_ext = {1'b0, offset} + LANE_AW'(nb);
      oob     = end_ext > LANE_AW'(SPACE_BYTES);
      for (int k = 0; k < LANES; k++) begin
         lane_addr[k] = {1'b0, offset} + LANE_AW'(k);
         lane_act[k]  = 3'(k) < nb;
      end
   end
endmodule

// File: rtl/cfgrf_byte_store.sv
module cfgrf_byte_store
   import cfgrf_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int MEM_BYTES = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [LANES-1:0][ADDR_W:0]  lane_addr,
   input  logic [LANES-1:0]            lane_act,
   input  logic [8*LANES-1:0]          wdata,
   input  logic                        init_valid,
   input  logic                        init_sel,
   input  logic [ADDR_W-1:0]           init_offset,
   input  logic [7:0]                  init_data,
   output logic [MEM_BYTES*8-1:0]      val_flat,
   output logic [MEM_BYTES*8-1:0]      msk_flat
);
   localparam int LANE_AW = ADDR_W + 1;

   for (genvar i = 0; i < MEM_BYTES; i++) begin : g_byte
      logic [7:0] v_q, m_q, v_d, m_d;

      always_comb begin
         v_d = v_q;
         m_d = m_q;
         for (int k = 0; k < LANES; k++) begin
            if (wr_en && lane_act[k] && lane_addr[k] == LANE_AW'(i))
               v_d = (v_q & ~m_q) | (wdata[8*k +: 8] & m_q);
         end
         if (init_valid && init_offset == ADDR_W'(i)) begin
            if (init_sel) m_d = init_data;
            else          v_d = init_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= '0;
            m_q <= '0;
         end else begin
            v_q <= v_d;
            m_q <= m_d;
         end
      end

      assign val_flat[8*i +: 8] = v_q;
      assign msk_flat[8*i +: 8] = m_q;
   end
endmodule

// File: rtl/cfgrf_read_pack.sv
module cfgrf_read_pack
   import cfgrf_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int MEM_BYTES = 64
) (
   input  logic [LANES-1:0][ADDR_W:0]  lane_addr,
   input  logic [LANES-1:0]            lane_act,
   input  logic                        oob,
   input  logic [MEM_BYTES*8-1:0]      val_flat,
   output logic [8*LANES-1:0]          rdata
);
   localparam int LANE_AW = ADDR_W + 1;
   localparam int IDX_W   = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

   always_comb begin
      rdata = '0;
      for (int k = 0; k < LANES; k++) begin
         if (lane_act[k]) begin
            if (oob)
               rdata[8*k +: 8] = 8'hFF;
            else if (lane_addr[k] < LANE_AW'(MEM_BYTES))
               rdata[8*k +: 8] = val_flat[8*int'(lane_addr[k][IDX_W-1:0]) +: 8];
         end
      end
   end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cfgrf_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int MEM_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [31:0]       req_wdata,
   input  logic              init_valid,
   input  logic              init_sel,
   input  logic [ADDR_W-1:0] init_offset,
   input  logic [7:0]        init_data,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata
);
   localparam int SPACE_BYTES = 1 << ADDR_W;

   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_aw
      $error("cfg_regfile: ADDR_W must lie in 3..16");
   end
   if (MEM_BYTES < 4 || MEM_BYTES > SPACE_BYTES) begin : g_bad_mem
      $error("cfg_regfile: MEM_BYTES must lie in 4..2**ADDR_W");
   end
   if ((MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_pow2
      $error("cfg_regfile: MEM_BYTES must be a power of two");
   end

   logic [LANES-1:0][ADDR_W:0] lane_addr;
   logic [LANES-1:0]           lane_act;
   logic                       oob;
   logic [MEM_BYTES*8-1:0]     val_flat;
   logic [MEM_BYTES*8-1:0]     msk_flat;
   logic [31:0]                rd_data;
   logic                       rd_req;
   logic                       wr_ok;

   assign rd_req = req_valid && !req_write;
   assign wr_ok  = req_valid && req_write && !oob;

   cfgrf_lane_decode #(.ADDR_W(ADDR_W)) u_decode (
      .offset    (req_offset),
      .size      (acc_size_e'(req_size)),
      .lane_addr (lane_addr),
      .lane_act  (lane_act),
      .oob       (oob)
   );

   cfgrf_byte_store #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_ok),
      .lane_addr   (lane_addr),
      .lane_act    (lane_act),
      .wdata       (req_wdata),
      .init_valid  (init_valid),
      .init_sel    (init_sel),
      .init_offset (init_offset),
      .init_data   (init_data),
      .val_flat    (val_flat),
      .msk_flat    (msk_flat)
   );

   cfgrf_read_pack #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_pack (
      .lane_addr (lane_addr),
      .lane_act  (lane_act),
      .oob       (oob),
      .val_flat  (val_flat),
      .rdata     (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_req;
         if (rd_req) rsp_rdata <= rd_data;
      end
   end
endmodule

// File: rtl/cfgrf_checker.sv
module cfgrf_checker #(
   parameter int ADDR_W    = 12,
   parameter int MEM_BYTES = 64
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_write,
   input logic [1:0]             req_size,
   input logic [ADDR_W-1:0]      req_offset,
   input logic                   init_valid,
   input logic                   rsp_valid,
   input logic [31:0]            rsp_rdata,
   input logic [MEM_BYTES*8-1:0] val_flat,
   input logic [MEM_BYTES*8-1:0] msk_flat
);
   localparam int SPACE_BYTES = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(SPACE_BYTES - 4);

   p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);

   p_byte_lanes_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd0) |=> rsp_rdata[31:8] == 24'd0);

   p_straddle_read_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size[1] && req_offset > LAST_WORD)
      |=> rsp_rdata == 32'hFFFF_FFFF);

   p_straddle_write_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size[1] && req_offset > LAST_WORD && !init_valid)
      |=> $stable(val_flat));

   p_mask_only_by_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !init_valid |=> $stable(msk_flat));

   p_idle_values_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_valid && !(req_valid && req_write)) |=> $stable(val_flat));
endmodule

bind cfg_regfile cfgrf_checker #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_size   (req_size),
   .req_offset (req_offset),
   .init_valid (init_valid),
   .rsp_valid  (rsp_valid),
   .rsp_rdata  (rsp_rdata),
   .val_flat   (val_flat),
   .msk_flat   (msk_flat)
);

// File: tb/cfg_regfile_tb_top.sv
module cfg_regfile_tb_top;
   localparam int AW  = 6;
   localparam int MEM = 64;
   localparam time HALF = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [1:0]    req_size = '0;
   logic [AW-1:0] req_offset = '0;
   logic [31:0]   req_wdata = '0;
   logic          init_valid = 1'b0;
   logic          init_sel = 1'b0;
   logic [AW-1:0] init_offset = '0;
   logic [7:0]    init_data = '0;
   logic          rsp_valid;
   logic [31:0]   rsp_rdata;

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #HALF clk = ~clk;

   cfg_regfile #(.ADDR_W(AW), .MEM_BYTES(MEM)) dut_i (
      .clk, .rst_n, .req_valid, .req_write, .req_size, .req_offset, .req_wdata,
      .init_valid, .init_sel, .init_offset, .init_data, .rsp_valid, .rsp_rdata
   );

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // monitor: pops one expected item per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R2 unexpected response: actual %h expected none", rsp_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rsp_rdata !== e) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
            end
         end
      end
   end

   task automatic do_read(input logic [AW-1:0] off, input logic [1:0] sz,
                          input logic [31:0] exp, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_offset = off;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [AW-1:0] off, input logic [1:0] sz,
                           input logic [31:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_offset = off;
      req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic do_load(input logic sel, input logic [AW-1:0] off, input logic [7:0] d);
      @(negedge clk);
      init_valid = 1'b1; init_sel = sel; init_offset = off; init_data = d;
      @(negedge clk);
      init_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      checks++;
      if (rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 rsp_valid after reset: actual %b expected 0", rsp_valid);
      end
      do_read(6'h00, 2'd2, 32'h0000_0000, "R1 reset read");

      // identity values and masks through the load port (R6)
      do_load(0, 6'h00, 8'h34); do_load(0, 6'h01, 8'h12);
      do_load(0, 6'h02, 8'h78); do_load(0, 6'h03, 8'h56);
      do_load(0, 6'h08, 8'h01); do_load(0, 6'h0B, 8'h06);
      do_load(1, 6'h04, 8'h07); do_load(1, 6'h05, 8'h05);
      do_load(1, 6'h10, 8'hF0); do_load(1, 6'h11, 8'hFF);
      do_load(1, 6'h12, 8'hFF); do_load(1, 6'h13, 8'hFF);
      for (int a = 60; a < 64; a++) do_load(1, AW'(a), 8'hFF);
      do_read(6'h00, 2'd2, 32'h5678_1234, "R6 loaded identity word");
      do_read(6'h08, 2'd2, 32'h0600_0001, "R6 loaded class word");
      do_read(6'h00, 2'd3, 32'h5678_1234, "R2 size code 3 is word");

      // R7 command register
      do_write(6'h04, 2'd1, 32'h0000_FFFF);
      do_read(6'h04, 2'd1, 32'h0000_0507, "R7 command writable bits");
      do_write(6'h04, 2'd1, 32'h0000_0000);
      do_read(6'h04, 2'd1, 32'h0000_0000, "R7 command cleared");

      // R8 identity read-only
      do_write(6'h00, 2'd2, 32'hFFFF_FFFF);
      do_write(6'h08, 2'd2, 32'h0000_0000);
      do_read(6'h00, 2'd2, 32'h5678_1234, "R8 identity unchanged");
      do_read(6'h08, 2'd2, 32'h0600_0001, "R8 class unchanged");

      // R3 sizing probe and merge
      do_write(6'h10, 2'd2, 32'hFFFF_FFFF);
      do_read(6'h10, 2'd2, 32'hFFFF_FFF0, "R3 sizing probe");
      do_write(6'h10, 2'd2, 32'hA5A5_A5A5);
      do_read(6'h10, 2'd2, 32'hA5A5_A5A0, "R3 base write");
      do_load(1, 6'h20, 8'h0F);
      do_load(0, 6'h20, 8'hA0);
      do_write(6'h20, 2'd0, 32'h0000_005C);
      do_read(6'h20, 2'd0, 32'h0000_00AC, "R3 partial mask merge");

      // R2 lane packing
      do_read(6'h0B, 2'd0, 32'h0000_0006, "R2 byte read");
      do_read(6'h02, 2'd1, 32'h0000_5678, "R2 half read");

      // edge of space (R9, R4, R5)
      do_write(6'h3C, 2'd2, 32'h1122_3344);
      do_read(6'h3C, 2'd2, 32'h1122_3344, "R9 last full word");
      do_read(6'h3D, 2'd1, 32'h0000_2233, "R9 misaligned in range");
      do_read(6'h3F, 2'd0, 32'h0000_0011, "R9 last byte");
      do_read(6'h3D, 2'd2, 32'hFFFF_FFFF, "R4 straddling word read");
      do_read(6'h3F, 2'd1, 32'h0000_FFFF, "R4 straddling half read");
      do_write(6'h3E, 2'd2, 32'hAAAA_AAAA);
      do_write(6'h3F, 2'd1, 32'h0000_5555);
      do_read(6'h3C, 2'd2, 32'h1122_3344, "R5 straddling writes dropped");

      // R6 load bypasses mask
      do_load(0, 6'h04, 8'hFF);
      do_load(0, 6'h05, 8'hFF);
      do_read(6'h04, 2'd1, 32'h0000_FFFF, "R6 load bypasses mask");

      // R10 same-cycle load and write
      do_load(1, 6'h21, 8'hFF);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_offset = 6'h21;
      req_wdata = 32'h0000_00EE;
      init_valid = 1'b1; init_sel = 1'b0; init_offset = 6'h21; init_data = 8'h12;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; init_valid = 1'b0;
      do_read(6'h21, 2'd0, 32'h0000_0012, "R10 load wins over write");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R2 missing responses: actual %0d pending expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule